// File: doc/BRIEF.md
# Two-Level Address Translation Lookup Unit

This unit turns a virtual page number into a physical page number for two requesters, one on the data side and one on the instruction side. Each requester owns a small first-level translation cache. A request that hits there is answered in the next cycle.

A request that misses its first level goes to a larger second-level translation cache that both requesters share. A hit there is answered after a fixed, configurable penalty. In the same clock edge that returns the answer, the requester's first level is written, so that translation is never looked up in the first level a second time.

When both levels miss, the unit asks an external page walker for the translation. It holds that request until the walker answers. The walker's answer is written into both levels and forwarded to the requester. A flush input empties both levels in one cycle and cancels any lookup in progress.

Top module: `tlb2_xlate`

## Requirements
- R1: A request accepted (`*_req_valid` and `*_req_ready` high at a clock edge) whose page is held in that side's first level returns `*_resp_valid` with the stored page number in the following cycle.
- R2: Each first level holds L1_SETS x L1_WAYS entries, with 16 sets of 4 ways by default. The set index is the low log2(L1_SETS) bits of the virtual page number. Filling one set never evicts an entry of another set.
- R3: A first-level miss that hits the shared second level answers MISS_PEN cycles later than a first-level hit would (default 7). The same edge writes the first level, so the next request for that page hits there.
- R4: The second level (L2_SETS x L2_WAYS, 128 x 4 by default, indexed by the low virtual page number bits) is shared: a translation brought in for one side hits in the second level for the other side.
- R5: A miss in both levels raises `walk_req_valid` with the page number MISS_PEN cycles after acceptance. It holds both stable until `walk_resp_valid`. The response goes to the requester at the same edge, and both levels are filled.
- R6: Replacement within a set uses one recently-used bit per way, set on every hit and fill. When all bits of a set would be set, only the accessed way's bit remains set. The victim is the lowest invalid way, or else the lowest way whose bit is clear.
- R7: When both sides wait for the second level, the data side is served first. The instruction request waits and is served as soon as the second level is free.
- R8: `flush` high at a clock edge invalidates every entry of both levels. It aborts any pending lookup, which then never responds, and drops `walk_req_valid`.
- R9: After reset both `*_req_ready` are high and no valid output is raised. A side holds one request at a time, and its `*_req_ready` is low while a request is pending.
- R10: A walk response arriving while no walk request is raised is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate both levels, abort pending lookups |
| d_req_valid | input | 1 | Data-side request |
| d_req_vpn | input | VPN_W | Data-side virtual page number |
| d_req_ready | output | 1 | Data side can accept a request |
| d_resp_valid | output | 1 | Data-side translation valid (one cycle) |
| d_resp_ppn | output | PPN_W | Data-side physical page number |
| i_req_valid | input | 1 | Instruction-side request |
| i_req_vpn | input | VPN_W | Instruction-side virtual page number |
| i_req_ready | output | 1 | Instruction side can accept a request |
| i_resp_valid | output | 1 | Instruction-side translation valid (one cycle) |
| i_resp_ppn | output | PPN_W | Instruction-side physical page number |
| walk_req_valid | output | 1 | Page walk requested |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_resp_valid | input | 1 | Walker answer valid |
| walk_resp_ppn | input | PPN_W | Walker physical page number |

## Verification
The hardest case to reach is the replacement choice. It only becomes visible when a fifth distinct page enters an already-full first-level set after one older way has been touched again. The stimulus picks pages that share a first-level set but spread across second-level sets. It fills the set through walks, re-touches one way, then adds the fifth page. Response latency then shows which page moved out: an evicted page answers after the second-level penalty, and a kept page answers in one cycle. Simultaneous misses from both sides on the same page drive the shared-level ordering, where the instruction side must see the data side's walk result as a second-level hit.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  typedef enum logic [1:0] {
    L2_IDLE  = 2'd0,
    L2_COUNT = 2'd1,
    L2_WALK  = 2'd2
  } l2_state_e;
endpackage

// File: rtl/tlb_set_array.sv
module tlb_set_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PPN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             touch_en,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [WAYS-1:0]  mru_q [SETS];
  logic [WAYS-1:0]  mru_d [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0]  lk_vec, fl_match;
  logic [WAY_W-1:0] lk_way, fl_way;
  logic             pick;

  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_vec[w]   = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
  end

  assign lk_hit = |lk_vec;

  always_comb begin
    lk_ppn = '0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_vec[w]) begin
        lk_ppn = lk_ppn | ppn_q[lk_set][w];
        lk_way = WAY_W'(w);
      end
    end
  end

  // victim: same page first, then lowest invalid, then lowest not-recent
  always_comb begin
    fl_way = '0;
    pick   = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!pick && fl_match[w]) begin fl_way = WAY_W'(w); pick = 1'b1; end
    for (int w = 0; w < WAYS; w++)
      if (!pick && !vld_q[fl_set][w]) begin fl_way = WAY_W'(w); pick = 1'b1; end
    for (int w = 0; w < WAYS; w++)
      if (!pick && !mru_q[fl_set][w]) begin fl_way = WAY_W'(w); pick = 1'b1; end
  end

  function automatic logic [WAYS-1:0] mark(input logic [WAYS-1:0] row,
                                           input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] r;
    r = row | (WAYS'(1) << w);
    if (&r) r = WAYS'(1) << w;
    return r;
  endfunction

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = vld_q[s];
      mru_d[s] = mru_q[s];
    end
    if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_d[s] = '0;
        mru_d[s] = '0;
      end
    end else begin
      if (touch_en && lk_hit) mru_d[lk_set] = mark(mru_d[lk_set], lk_way);
      if (fill_en) begin
        vld_d[fl_set][fl_way] = 1'b1;
        mru_d[fl_set]         = mark(mru_d[fl_set], fl_way);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mru_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= vld_d[s];
        mru_q[s] <= mru_d[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fl_set][fl_way] <= fl_tag;
      ppn_q[fl_set][fl_way] <= fill_ppn;
    end
  end
endmodule

// File: rtl/tlb_front.sv
module tlb_front #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PPN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             pend,
  output logic [VPN_W-1:0] pend_vpn,
  input  logic             dlv_en,
  input  logic [PPN_W-1:0] dlv_ppn
);
  logic             busy_q, busy_d;
  logic [VPN_W-1:0] vpn_q;
  logic             rv_d;
  logic [PPN_W-1:0] rp_d;
  logic             accept, hit, land;
  logic [PPN_W-1:0] hit_ppn;

  assign req_ready = !busy_q && !flush;
  assign accept    = req_valid && req_ready;
  assign land      = dlv_en && busy_q && !flush;
  assign pend      = busy_q;
  assign pend_vpn  = vpn_q;

  tlb_set_array #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l1 (
    .clk, .rst_n, .flush,
    .lk_vpn(req_vpn), .touch_en(accept), .lk_hit(hit), .lk_ppn(hit_ppn),
    .fill_en(land), .fill_vpn(vpn_q), .fill_ppn(dlv_ppn)
  );

  always_comb begin
    busy_d = busy_q;
    if (flush)              busy_d = 1'b0;
    else if (accept && !hit) busy_d = 1'b1;
    else if (land)          busy_d = 1'b0;
    rv_d = (accept && hit) || land;
    rp_d = accept ? hit_ppn : dlv_ppn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      resp_valid <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      resp_valid <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) vpn_q    <= req_vpn;
    if (rv_d)   resp_ppn <= rp_d;
  end
endmodule

// File: rtl/tlb_l2_ctrl.sv
module tlb_l2_ctrl
  import tlb2_pkg::*;
#(
  parameter int SETS     = 128,
  parameter int WAYS     = 4,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 16,
  parameter int MISS_PEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             d_pend,
  input  logic [VPN_W-1:0] d_vpn,
  input  logic             i_pend,
  input  logic [VPN_W-1:0] i_vpn,
  output logic             d_dlv,
  output logic             i_dlv,
  output logic [PPN_W-1:0] dlv_ppn,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_resp_valid,
  input  logic [PPN_W-1:0] walk_resp_ppn
);
  localparam int CNT_W = $clog2(MISS_PEN + 1);

  l2_state_e        st_q, st_d;
  logic             sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic             wr_d;
  logic             due, hit, dlv_go, fill;
  logic [PPN_W-1:0] hit_ppn;

  assign due    = (st_q == L2_COUNT) && (cnt_q == CNT_W'(MISS_PEN)) && !flush;
  assign fill   = (st_q == L2_WALK) && walk_resp_valid && !flush;
  assign dlv_go = (due && hit) || fill;
  assign d_dlv  = dlv_go && !sel_q;
  assign i_dlv  = dlv_go && sel_q;
  assign dlv_ppn      = (st_q == L2_WALK) ? walk_resp_ppn : hit_ppn;
  assign walk_req_vpn = vpn_q;

  tlb_set_array #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l2 (
    .clk, .rst_n, .flush,
    .lk_vpn(vpn_q), .touch_en(due), .lk_hit(hit), .lk_ppn(hit_ppn),
    .fill_en(fill), .fill_vpn(vpn_q), .fill_ppn(walk_resp_ppn)
  );

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    cnt_d = cnt_q;
    vpn_d = vpn_q;
    wr_d  = walk_req_valid;
    if (flush) begin
      st_d = L2_IDLE;
      wr_d = 1'b0;
    end else begin
      unique case (st_q)
        L2_IDLE: if (d_pend || i_pend) begin
          sel_d = !d_pend;               // data side wins
          vpn_d = d_pend ? d_vpn : i_vpn;
          cnt_d = CNT_W'(2);
          st_d  = L2_COUNT;
        end
        L2_COUNT: if (cnt_q == CNT_W'(MISS_PEN)) begin
          if (hit) st_d = L2_IDLE;
          else begin
            st_d = L2_WALK;
            wr_d = 1'b1;
          end
        end else cnt_d = cnt_q + CNT_W'(1);
        L2_WALK: if (walk_resp_valid) begin
          st_d = L2_IDLE;
          wr_d = 1'b0;
        end
        default: st_d = L2_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= L2_IDLE;
      walk_req_valid <= 1'b0;
    end else begin
      st_q           <= st_d;
      walk_req_valid <= wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == L2_IDLE) begin
      sel_q <= sel_d;
      vpn_q <= vpn_d;
    end
    cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tlb2_xlate.sv
module tlb2_xlate #(
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 16,
  parameter int L1_SETS  = 16,
  parameter int L1_WAYS  = 4,
  parameter int L2_SETS  = 128,
  parameter int L2_WAYS  = 4,
  parameter int MISS_PEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             d_req_valid,
  input  logic [VPN_W-1:0] d_req_vpn,
  output logic             d_req_ready,
  output logic             d_resp_valid,
  output logic [PPN_W-1:0] d_resp_ppn,
  input  logic             i_req_valid,
  input  logic [VPN_W-1:0] i_req_vpn,
  output logic             i_req_ready,
  output logic             i_resp_valid,
  output logic [PPN_W-1:0] i_resp_ppn,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_resp_valid,
  input  logic [PPN_W-1:0] walk_resp_ppn
);
  logic             d_pend, i_pend, d_dlv, i_dlv;
  logic [VPN_W-1:0] d_pvpn, i_pvpn;
  logic [PPN_W-1:0] dlv_ppn;

  tlb_front #(.SETS(L1_SETS), .WAYS(L1_WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dside (
    .clk, .rst_n, .flush,
    .req_valid(d_req_valid), .req_vpn(d_req_vpn), .req_ready(d_req_ready),
    .resp_valid(d_resp_valid), .resp_ppn(d_resp_ppn),
    .pend(d_pend), .pend_vpn(d_pvpn), .dlv_en(d_dlv), .dlv_ppn(dlv_ppn)
  );

  tlb_front #(.SETS(L1_SETS), .WAYS(L1_WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_iside (
    .clk, .rst_n, .flush,
    .req_valid(i_req_valid), .req_vpn(i_req_vpn), .req_ready(i_req_ready),
    .resp_valid(i_resp_valid), .resp_ppn(i_resp_ppn),
    .pend(i_pend), .pend_vpn(i_pvpn), .dlv_en(i_dlv), .dlv_ppn(dlv_ppn)
  );

  tlb_l2_ctrl #(.SETS(L2_SETS), .WAYS(L2_WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W),
                .MISS_PEN(MISS_PEN)) u_shared (
    .clk, .rst_n, .flush,
    .d_pend, .d_vpn(d_pvpn), .i_pend, .i_vpn(i_pvpn),
    .d_dlv, .i_dlv, .dlv_ppn,
    .walk_req_valid, .walk_req_vpn, .walk_resp_valid, .walk_resp_ppn
  );
endmodule

// File: rtl/tlb2_xlate_chk.sv
module tlb2_xlate_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             d_req_valid,
  input logic             d_req_ready,
  input logic             d_resp_valid,
  input logic             i_req_valid,
  input logic             i_req_ready,
  input logic             i_resp_valid,
  input logic             walk_req_valid,
  input logic [VPN_W-1:0] walk_req_vpn,
  input logic             walk_resp_valid
);
  p_walk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_resp_valid && !flush) |=> (walk_req_valid && $stable(walk_req_vpn)));

  p_walk_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> (!d_req_ready || !i_req_ready));

  p_flush_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!d_resp_valid && !i_resp_valid && !walk_req_valid));

  p_dside_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid && d_req_ready) |=> (d_resp_valid || !d_req_ready));

  p_iside_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req_valid && i_req_ready) |=> (i_resp_valid || !i_req_ready));
endmodule

bind tlb2_xlate tlb2_xlate_chk #(.VPN_W(VPN_W)) u_chk (
  .clk, .rst_n, .flush, .d_req_valid, .d_req_ready, .d_resp_valid,
  .i_req_valid, .i_req_ready, .i_resp_valid,
  .walk_req_valid, .walk_req_vpn, .walk_resp_valid
);

// File: tb/tlb2_xlate_test.sv
module tlb2_xlate_test;
  localparam int VPN_W = 20;
  localparam int PPN_W = 16;
  localparam int PEN   = 7;
  localparam int WD    = 3;

  logic clk, rst_n, flush;
  logic req_v [2];
  logic [VPN_W-1:0] req_vpn [2];
  logic rdy [2];
  logic rv [2];
  logic [PPN_W-1:0] rp [2];
  logic walk_req_valid;
  logic [VPN_W-1:0] walk_req_vpn;
  logic w_v, stray_v;
  logic [PPN_W-1:0] w_p, stray_p;
  logic walk_resp_valid;
  logic [PPN_W-1:0] walk_resp_ppn;
  int checks, fails;

  assign walk_resp_valid = w_v | stray_v;
  assign walk_resp_ppn   = stray_v ? stray_p : w_p;

  tlb2_xlate #(.VPN_W(VPN_W), .PPN_W(PPN_W), .MISS_PEN(PEN)) uut (
    .clk, .rst_n, .flush,
    .d_req_valid(req_v[0]), .d_req_vpn(req_vpn[0]), .d_req_ready(rdy[0]),
    .d_resp_valid(rv[0]), .d_resp_ppn(rp[0]),
    .i_req_valid(req_v[1]), .i_req_vpn(req_vpn[1]), .i_req_ready(rdy[1]),
    .i_resp_valid(rv[1]), .i_resp_ppn(rp[1]),
    .walk_req_valid, .walk_req_vpn, .walk_resp_valid, .walk_resp_ppn
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int pmap(input int vpn);
    return (vpn * 7 + 'h123) & 'hFFFF;
  endfunction

  // behavioural walker: answers WD cycles after seeing a request
  initial begin
    w_v = 1'b0; w_p = '0;
    forever begin
      @(negedge clk);
      if (walk_req_valid) begin
        for (int k = 1; k < WD; k++) begin
          @(negedge clk);
          if (!walk_req_valid) break;
        end
        if (walk_req_valid) begin
          w_v = 1'b1; w_p = PPN_W'(pmap(int'(walk_req_vpn)));
          @(negedge clk);
          w_v = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model: level 0 = data L1, 1 = instr L1, 2 = shared L2
  int m_vld [3][512];
  int m_tag [3][512];
  int m_ppn [3][512];
  int m_mru [3][512];

  function automatic int nsets(input int l);
    return (l == 2) ? 128 : 16;
  endfunction

  function automatic int m_find(input int l, input int vpn);
    int s = vpn % nsets(l);
    for (int w = 0; w < 4; w++)
      if (m_vld[l][s*4+w] != 0 && m_tag[l][s*4+w] == vpn / nsets(l)) return w;
    return -1;
  endfunction

  function automatic void m_touch(input int l, input int s, input int w);
    int all = 1;
    m_mru[l][s*4+w] = 1;
    for (int k = 0; k < 4; k++) if (m_mru[l][s*4+k] == 0) all = 0;
    if (all != 0) for (int k = 0; k < 4; k++) m_mru[l][s*4+k] = (k == w) ? 1 : 0;
  endfunction

  function automatic void m_fill(input int l, input int vpn, input int ppn);
    int s = vpn % nsets(l);
    int w = m_find(l, vpn);
    if (w < 0) for (int k = 3; k >= 0; k--) if (m_vld[l][s*4+k] == 0) w = k;
    if (w < 0) for (int k = 3; k >= 0; k--) if (m_mru[l][s*4+k] == 0) w = k;
    m_vld[l][s*4+w] = 1; m_tag[l][s*4+w] = vpn / nsets(l); m_ppn[l][s*4+w] = ppn;
    m_touch(l, s, w);
  endfunction

  function automatic void m_clear();
    for (int l = 0; l < 3; l++)
      for (int e = 0; e < 512; e++) begin m_vld[l][e] = 0; m_mru[l][e] = 0; end
  endfunction

  task automatic predict(input int side, input int vpn, output int lat, output int ppn);
    int w = m_find(side, vpn);
    if (w >= 0) begin
      m_touch(side, vpn % 16, w); ppn = m_ppn[side][(vpn%16)*4+w]; lat = 1;
    end else begin
      w = m_find(2, vpn);
      if (w >= 0) begin
        m_touch(2, vpn % 128, w); ppn = m_ppn[2][(vpn%128)*4+w]; lat = PEN + 1;
      end else begin
        ppn = pmap(vpn); m_fill(2, vpn, ppn); lat = PEN + WD + 1;
      end
      m_fill(side, vpn, ppn);
    end
  endtask

  task automatic watch(input int side, input int lat, input int ppn, input string tag);
    int got = -1;
    int gp = 0;
    for (int n = 1; n <= lat + 40; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_v[side] = 1'b0;
        if (lat > 1) check(!rdy[side], {tag, " R9 busy"}, int'(rdy[side]), 0);
      end
      if (rv[side]) begin got = n; gp = int'(rp[side]); break; end
    end
    check(got == lat, {tag, " latency"}, got, lat);
    check(gp == ppn, {tag, " ppn"}, gp, ppn);
  endtask

  task automatic run(input int side, input int vpn, input string tag);
    int lat, ppn;
    predict(side, vpn, lat, ppn);
    req_v[side] = 1'b1; req_vpn[side] = VPN_W'(vpn);
    watch(side, lat, ppn, tag);
  endtask

  task automatic run_both(input int vd, input int vi, input string tag);
    int dl, dp, il, ip;
    predict(0, vd, dl, dp);
    predict(1, vi, il, ip);
    if (dl > 1 && il > 1) il = il + dl - 1;   // R7: instruction side waits
    req_v[0] = 1'b1; req_vpn[0] = VPN_W'(vd);
    req_v[1] = 1'b1; req_vpn[1] = VPN_W'(vi);
    fork
      watch(0, dl, dp, {tag, " data"});
      watch(1, il, ip, {tag, " instr"});
    join
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    checks = 0; fails = 0;
    rst_n = 1'b0; flush = 1'b0; stray_v = 1'b0; stray_p = '0;
    for (int s = 0; s < 2; s++) begin req_v[s] = 1'b0; req_vpn[s] = '0; end
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy[0] && rdy[1], "R9 reset ready", int'(rdy[0]), 1);
    check(!rv[0] && !rv[1] && !walk_req_valid, "R9 reset outputs", int'(walk_req_valid), 0);

    run(0, 'h00010, "R5 data walk");
    run(0, 'h00010, "R1 data L1 hit");
    run(1, 'h00010, "R4 instr shared L2 hit");
    run(1, 'h00010, "R3 instr L1 refilled");
    run(0, 'h00011, "R2 other set walk");
    run(0, 'h00010, "R2 first set kept");

    // R6: five pages in L1 set 5, distinct L2 sets
    for (int k = 0; k < 4; k++) run(0, 'h205 + 16*k, "R6 fill set");
    run(0, 'h205, "R6 touch way0");
    run(0, 'h205 + 64, "R6 fifth page");
    run(0, 'h205 + 16, "R6 evicted page from L2");
    run(0, 'h205, "R6 touched page kept");
    run(0, 'h205 + 48, "R6 newest kept");

    run_both('h3001, 'h3002, "R7 both walk");
    run_both('h4000, 'h4000, "R7 R4 same page");
    run_both('h3001, 'h3002, "R1 both L1 hit");

    // R8: flush during a pending lookup
    req_v[0] = 1'b1; req_vpn[0] = VPN_W'('h5555);
    @(negedge clk); req_v[0] = 1'b0;
    repeat (3) @(negedge clk);
    flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    bad = 0;
    for (int n = 0; n < 20; n++) begin
      if (rv[0] || rv[1] || walk_req_valid) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 aborted lookup silent", bad, 0);
    check(rdy[0] && rdy[1], "R8 ready after flush", int'(rdy[0]), 1);
    m_clear();
    run(0, 'h00010, "R8 entry gone after flush");
    run(1, 'h00010, "R8 L2 refilled after flush");

    // R10: stray walk response
    stray_p = 16'hBEEF; stray_v = 1'b1;
    @(negedge clk); stray_v = 1'b0;
    @(negedge clk);
    check(!rv[0] && !rv[1], "R10 no response to stray", int'(rv[0]), 0);
    run(1, 'h7777, "R10 walk after stray");
    run(0, 'h7777, "R10 shared entry correct");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule